// File: doc/BRIEF.md
# Machine State Register Write Controller

This block holds a processor's 64-bit machine state register and applies the write rules to every software update. A written value is first reduced to the implemented bits. The hypervisor bit is then protected. On a 64-bit server core, entering problem state also forces three bits on. The new value is committed on the clock edge of the write strobe.

The same edge registers the side effects of the write:
- a one-cycle translation-context flush pulse when either translation-enable bit changes;
- a one-cycle request to exchange general registers 0 to 3 with their shadow copies;
- an update of the exception-vector prefix;
- a halt request when power saving is asked for while no interrupt is pending.

A packed flag vector is derived from the register contents. It carries pass-through bits, a hypervisor flag, and separate instruction-side and data-side translation-mode indices. The layout of those indices depends on the memory-management variant chosen by parameter. Instruction decode and the general register file sit outside this block. The block only signals the swap; it does not perform it.

Top module: `msr_write_ctrl`

## Requirements
- R1: On a write, every bit of the written data whose position is 0 in the implemented-bits parameter is stored as 0 (default: bit 40 is unimplemented).
- R2: The hypervisor bit (default bit 60) takes the written value only when the write's alter-hypervisor input is 1 and the stored hypervisor bit is already 1; otherwise it keeps its old value.
- R3: With the 64-bit server option on, a write that stores problem-state (bit 14) as 1 also stores external-interrupt-enable (bit 15), instruction translation (bit 5) and data translation (bit 4) as 1.
- R4: `flush_o` is 1 for exactly the one cycle after a write edge at which bit 5 or bit 4 of the register changed value, and 0 otherwise.
- R5: With the shadow option on, `swap_o` is 1 for exactly the one cycle after a write edge at which the temporary-register bit (bit 17) changed value, and 0 otherwise.
- R6: When a write changes the exception-prefix bit (bit 6), `prefix_o` becomes 0xFFF00000 if the new bit is 1 and 0 if it is 0. Otherwise it holds its value.
- R7: `halt_o` becomes 1 after a write whose stored value has the power-save bit (bit 18) set, provided `irq_pending` is 0 and `pow_permit` is 1 at that edge.
- R8: `halt_o` is cleared on the edge after any cycle with `irq_pending` at 1, and by reset.
- R9: `flags_o` is packed {le(bit 0), fp(bit 13), dr(bit 4), pr(bit 14), hv, immu[2:0], dmmu[2:0]}, MSB first (11 bits). hv is 1 when the core has no hypervisor mode or the hypervisor bit is 1.
- R10: In the server variant, for both indices, bit 0 of an index is 1 when problem-state is 0 and bit 2 is the hypervisor bit. Bit 1 of dmmu is 1 when bit 4 is 0, and bit 1 of immu is 1 when bit 5 is 0.
- R11: In the embedded variant, bit 0 of each index is 1 when problem-state is 0, and bit 2 is the guest-state bit (bit 28). Bit 1 of dmmu is the data address-space bit (bit 4) and bit 1 of immu is the instruction address-space bit (bit 5).
- R12: While `rst_n` is 0 at a clock edge, the register loads the reset-value parameter (default: only the hypervisor bit set), and `flush_o`, `swap_o`, `prefix_o` and `halt_o` become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | XLEN | Value written by software |
| wr_alter_hv | input | 1 | Write may change the hypervisor bit |
| irq_pending | input | 1 | An interrupt is pending |
| pow_permit | input | 1 | Power saving is permitted |
| msr_o | output | XLEN | Current register value |
| flags_o | output | 11 | Derived flag vector |
| flush_o | output | 1 | Translation-context flush pulse |
| swap_o | output | 1 | Shadow register bank swap pulse |
| prefix_o | output | XLEN | Exception-vector prefix |
| halt_o | output | 1 | Halt request |

## Verification
The hardest state to reach is one where the hypervisor bit can change at all. It can be cleared only while it is still set, and once clear no write can set it again. The stimulus therefore starts from the reset value, and its first writes use alter-hypervisor both with the bit set and after it has been cleared. A reset is issued part way through the random phase to reopen that window. Halt is reached by writes that set the power-save bit with the permit high and no interrupt, followed later by interrupts. The embedded-variant index layout is covered by a second instance that receives the same writes.

// File: rtl/msr_pkg.sv
// Package: shared types and constants of the machine state register controller.
// Assumes: the flag vector layout below is decoded by neighbouring logic.
package msr_pkg;

    // Derived flag vector, most significant field first.
    typedef struct packed {
        logic       le;
        logic       fp;
        logic       dr;
        logic       pr;
        logic       hv;
        logic [2:0] immu;
        logic [2:0] dmmu;
    } msr_flags_t;

    localparam int FLAGS_W = $bits(msr_flags_t);

    // Prefix value used when the exception-prefix bit is set.
    localparam logic [31:0] PREFIX_HIGH = 32'hFFF0_0000;

endpackage

// File: rtl/msr_filter.sv
// Module: msr_filter
// Turns a software write into the value to be stored. It applies the
// implemented-bits mask, protects the hypervisor bit and forces the bits
// that problem state requires on a 64-bit server core.
// Assumes: purely combinational; the caller registers the result.
module msr_filter #(
    parameter int              XLEN      = 64,
    parameter logic [XLEN-1:0] IMPL_MASK = '1,
    parameter int              HV_BIT    = 60,
    parameter int              PR_BIT    = 14,
    parameter int              EE_BIT    = 15,
    parameter int              IR_BIT    = 5,
    parameter int              DR_BIT    = 4,
    parameter bit              SERVER64  = 1'b1
) (
    input  logic [XLEN-1:0] cur_msr,
    input  logic [XLEN-1:0] wr_data,
    input  logic            alter_hv,
    output logic [XLEN-1:0] nxt_msr
);

    localparam logic [XLEN-1:0] ONE        = {{(XLEN-1){1'b0}}, 1'b1};
    localparam logic [XLEN-1:0] HV_MASK    = ONE << HV_BIT;
    localparam logic [XLEN-1:0] FORCE_MASK = (ONE << EE_BIT) | (ONE << IR_BIT) | (ONE << DR_BIT);

    logic [XLEN-1:0] masked;
    logic [XLEN-1:0] hv_kept;
    logic            hv_writable;

    // Purpose: remove unimplemented bits from the written value.
    always_comb masked = wr_data & IMPL_MASK;

    // Purpose: the hypervisor bit changes only on a privileged write made in hypervisor state.
    always_comb begin
        hv_writable = alter_hv && cur_msr[HV_BIT];
        hv_kept     = hv_writable ? masked : ((masked & ~HV_MASK) | (cur_msr & HV_MASK));
    end

    // Purpose: apply the problem-state forcing rule where the variant asks for it.
    generate
        if (SERVER64) begin : g_force
            always_comb nxt_msr = hv_kept[PR_BIT] ? (hv_kept | FORCE_MASK) : hv_kept;
        end else begin : g_noforce
            always_comb nxt_msr = hv_kept;
        end
    endgenerate

endmodule

// File: rtl/msr_flags.sv
// Module: msr_flags
// Derives the packed flag vector, including both translation-mode
// indices, from the stored register value.
// Assumes: combinational; the variant is fixed by parameter.
module msr_flags
    import msr_pkg::*;
#(
    parameter int XLEN         = 64,
    parameter int HV_BIT       = 60,
    parameter int PR_BIT       = 14,
    parameter int IR_BIT       = 5,
    parameter int DR_BIT       = 4,
    parameter int LE_BIT       = 0,
    parameter int FP_BIT       = 13,
    parameter int GS_BIT       = 28,
    parameter int IS_BIT       = 5,
    parameter int DS_BIT       = 4,
    parameter bit HAS_HV       = 1'b1,
    parameter bit EMBEDDED_MMU = 1'b0
) (
    input  logic [XLEN-1:0] msr,
    output msr_flags_t      flags
);

    logic       sup;
    logic       upper;
    logic       i_mid;
    logic       d_mid;

    // Purpose: index bit 0 marks supervisor state in both variants.
    always_comb sup = !msr[PR_BIT];

    // Purpose: choose the sources of index bits 2 and 1 for the variant.
    generate
        if (EMBEDDED_MMU) begin : g_emb
            always_comb begin
                upper = msr[GS_BIT];
                i_mid = msr[IS_BIT];
                d_mid = msr[DS_BIT];
            end
        end else begin : g_srv
            always_comb begin
                upper = msr[HV_BIT];
                i_mid = !msr[IR_BIT];
                d_mid = !msr[DR_BIT];
            end
        end
    endgenerate

    // Purpose: pack the pass-through bits, the hypervisor flag and both indices.
    always_comb begin
        flags.le   = msr[LE_BIT];
        flags.fp   = msr[FP_BIT];
        flags.dr   = msr[DR_BIT];
        flags.pr   = msr[PR_BIT];
        flags.hv   = !HAS_HV || msr[HV_BIT];
        flags.immu = {upper, i_mid, sup};
        flags.dmmu = {upper, d_mid, sup};
    end

endmodule

// File: rtl/msr_effects.sv
// Module: msr_effects
// Registers the side effects of a committed write: the flush and swap
// pulses, the exception prefix and the halt request.
// Assumes: old_msr/new_msr are the values before and after the same edge.
module msr_effects
    import msr_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int IR_BIT    = 5,
    parameter int DR_BIT    = 4,
    parameter int TGPR_BIT  = 17,
    parameter int EP_BIT    = 6,
    parameter int POW_BIT   = 18,
    parameter bit SHADOW_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic [XLEN-1:0] old_msr,
    input  logic [XLEN-1:0] new_msr,
    input  logic            irq_pending,
    input  logic            pow_permit,
    output logic            flush_o,
    output logic            swap_o,
    output logic [XLEN-1:0] prefix_o,
    output logic            halt_o
);

    localparam logic [XLEN-1:0] PREFIX_ON = XLEN'(PREFIX_HIGH);

    logic xlate_change;
    logic ep_change;
    logic halt_req;

    // Purpose: detect the write conditions that raise side effects.
    always_comb begin
        xlate_change = (old_msr[IR_BIT] ^ new_msr[IR_BIT]) | (old_msr[DR_BIT] ^ new_msr[DR_BIT]);
        ep_change    = old_msr[EP_BIT] ^ new_msr[EP_BIT];
        halt_req     = new_msr[POW_BIT] && !irq_pending && pow_permit;
    end

    // Purpose: one-cycle flush pulse on a translation-enable change.
    always_ff @(posedge clk) begin
        if (!rst_n) flush_o <= 1'b0;
        else        flush_o <= commit && xlate_change;
    end

    // Purpose: one-cycle swap pulse on a temporary-register bit change, if present.
    generate
        if (SHADOW_EN) begin : g_swap
            always_ff @(posedge clk) begin
                if (!rst_n) swap_o <= 1'b0;
                else        swap_o <= commit && (old_msr[TGPR_BIT] ^ new_msr[TGPR_BIT]);
            end
        end else begin : g_noswap
            always_comb swap_o = 1'b0;
        end
    endgenerate

    // Purpose: update the exception prefix when the prefix bit changes.
    always_ff @(posedge clk) begin
        if (!rst_n)                      prefix_o <= '0;
        else if (commit && ep_change)    prefix_o <= new_msr[EP_BIT] ? PREFIX_ON : '0;
    end

    // Purpose: set halt on a power-save write, clear it on any pending interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)                    halt_o <= 1'b0;
        else if (irq_pending)          halt_o <= 1'b0;
        else if (commit && halt_req)   halt_o <= 1'b1;
    end

    // R8: a pending interrupt always clears halt on the next edge.
    a_r8_irq_clears_halt: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |=> !halt_o);

    // R4: flush pulses last one cycle only.
    a_r4_flush_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o && !commit |=> !flush_o);

endmodule

// File: rtl/msr_write_ctrl.sv
// Module: msr_write_ctrl (top)
// Holds the machine state register, commits filtered software writes and
// exposes the derived flags and the registered side-effect outputs.
// Assumes: one write per strobe; all outputs change on the write edge.
module msr_write_ctrl
    import msr_pkg::*;
#(
    parameter int              XLEN         = 64,
    parameter logic [XLEN-1:0] IMPL_MASK    = 64'hFFFF_FEFF_FFFF_FFFF,
    parameter logic [XLEN-1:0] RESET_MSR    = 64'h1000_0000_0000_0000,
    parameter int              HV_BIT       = 60,
    parameter int              PR_BIT       = 14,
    parameter int              EE_BIT       = 15,
    parameter int              IR_BIT       = 5,
    parameter int              DR_BIT       = 4,
    parameter int              LE_BIT       = 0,
    parameter int              FP_BIT       = 13,
    parameter int              TGPR_BIT     = 17,
    parameter int              EP_BIT       = 6,
    parameter int              POW_BIT      = 18,
    parameter int              GS_BIT       = 28,
    parameter int              IS_BIT       = 5,
    parameter int              DS_BIT       = 4,
    parameter bit              HAS_HV       = 1'b1,
    parameter bit              SERVER64     = 1'b1,
    parameter bit              SHADOW_EN    = 1'b1,
    parameter bit              EMBEDDED_MMU = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [XLEN-1:0]     wr_data,
    input  logic                wr_alter_hv,
    input  logic                irq_pending,
    input  logic                pow_permit,
    output logic [XLEN-1:0]     msr_o,
    output logic [FLAGS_W-1:0]  flags_o,
    output logic                flush_o,
    output logic                swap_o,
    output logic [XLEN-1:0]     prefix_o,
    output logic                halt_o
);

    logic [XLEN-1:0] msr_q;
    logic [XLEN-1:0] msr_nxt;
    msr_flags_t      flags;

    msr_filter #(
        .XLEN(XLEN), .IMPL_MASK(IMPL_MASK), .HV_BIT(HV_BIT), .PR_BIT(PR_BIT),
        .EE_BIT(EE_BIT), .IR_BIT(IR_BIT), .DR_BIT(DR_BIT), .SERVER64(SERVER64)
    ) u_filter (
        .cur_msr(msr_q), .wr_data(wr_data), .alter_hv(wr_alter_hv), .nxt_msr(msr_nxt)
    );

    // Purpose: commit the filtered value on the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     msr_q <= RESET_MSR;
        else if (wr_en) msr_q <= msr_nxt;
    end

    msr_effects #(
        .XLEN(XLEN), .IR_BIT(IR_BIT), .DR_BIT(DR_BIT), .TGPR_BIT(TGPR_BIT),
        .EP_BIT(EP_BIT), .POW_BIT(POW_BIT), .SHADOW_EN(SHADOW_EN)
    ) u_effects (
        .clk(clk), .rst_n(rst_n), .commit(wr_en), .old_msr(msr_q), .new_msr(msr_nxt),
        .irq_pending(irq_pending), .pow_permit(pow_permit),
        .flush_o(flush_o), .swap_o(swap_o), .prefix_o(prefix_o), .halt_o(halt_o)
    );

    msr_flags #(
        .XLEN(XLEN), .HV_BIT(HV_BIT), .PR_BIT(PR_BIT), .IR_BIT(IR_BIT), .DR_BIT(DR_BIT),
        .LE_BIT(LE_BIT), .FP_BIT(FP_BIT), .GS_BIT(GS_BIT), .IS_BIT(IS_BIT), .DS_BIT(DS_BIT),
        .HAS_HV(HAS_HV), .EMBEDDED_MMU(EMBEDDED_MMU)
    ) u_flags (
        .msr(msr_q), .flags(flags)
    );

    // Purpose: drive the register and flag outputs.
    always_comb begin
        msr_o   = msr_q;
        flags_o = flags;
    end

    // R2: a clear hypervisor bit can never become set again.
    a_r2_hv_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(msr_q[HV_BIT]) && $past(rst_n) |-> !msr_q[HV_BIT]);

    // R1: unimplemented bits are never set by a write.
    a_r1_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) && $past(rst_n) |-> (msr_q & ~IMPL_MASK) == '0);

    // R3: problem state on a server core implies the forced bits.
    a_r3_pr_forces: assert property (@(posedge clk) disable iff (!rst_n)
        SERVER64 && msr_q[PR_BIT] |-> msr_q[EE_BIT] && msr_q[IR_BIT] && msr_q[DR_BIT]);

    // R4: a flush pulse means a translation-enable bit just changed.
    a_r4_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (msr_q[IR_BIT] != $past(msr_q[IR_BIT])) || (msr_q[DR_BIT] != $past(msr_q[DR_BIT])));

    // R5: a swap pulse means the temporary-register bit just toggled.
    a_r5_swap_cause: assert property (@(posedge clk) disable iff (!rst_n)
        swap_o |-> msr_q[TGPR_BIT] != $past(msr_q[TGPR_BIT]));

    // R7: halt rises only with the power-save bit set.
    a_r7_halt_needs_pow: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_o) |-> msr_q[POW_BIT]);

endmodule

// File: tb/msr_write_ctrl_bench.sv
`timescale 1ns/1ps
module msr_write_ctrl_bench;

    localparam int HV = 60, PR = 14, EE = 15, IR = 5, DR = 4, LE = 0, FP = 13;
    localparam int TG = 17, EP = 6, POW = 18, GS = 28, IS = 5, DS = 4;
    localparam logic [63:0] MASK   = 64'hFFFF_FEFF_FFFF_FFFF;
    localparam logic [63:0] RST_S  = 64'h1000_0000_0000_0000;
    localparam logic [63:0] RST_E  = 64'h0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        wr_alter_hv = 1'b0;
    logic        irq_pending = 1'b0;
    logic        pow_permit = 1'b0;

    logic [63:0] msr_s, msr_e, pre_s, pre_e;
    logic [10:0] flg_s, flg_e;
    logic        fl_s, fl_e, sw_s, sw_e, ht_s, ht_e;

    int total = 0;
    int bad = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    msr_write_ctrl #(.IMPL_MASK(MASK), .RESET_MSR(RST_S), .HAS_HV(1'b1), .SERVER64(1'b1),
                     .SHADOW_EN(1'b1), .EMBEDDED_MMU(1'b0)) u_msr_write_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_alter_hv(wr_alter_hv),
        .irq_pending(irq_pending), .pow_permit(pow_permit), .msr_o(msr_s), .flags_o(flg_s),
        .flush_o(fl_s), .swap_o(sw_s), .prefix_o(pre_s), .halt_o(ht_s));

    msr_write_ctrl #(.IMPL_MASK(MASK), .RESET_MSR(RST_E), .HAS_HV(1'b0), .SERVER64(1'b0),
                     .SHADOW_EN(1'b1), .EMBEDDED_MMU(1'b1)) u_emb (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_alter_hv(wr_alter_hv),
        .irq_pending(irq_pending), .pow_permit(pow_permit), .msr_o(msr_e), .flags_o(flg_e),
        .flush_o(fl_e), .swap_o(sw_e), .prefix_o(pre_e), .halt_o(ht_e));

    // Reference model state, index 0 = server instance, 1 = embedded instance.
    logic [63:0] m_msr [2];
    logic [63:0] m_pre [2];
    logic        m_fl  [2];
    logic        m_sw  [2];
    logic        m_ht  [2];

    function automatic logic [63:0] ref_next(input int v, input logic [63:0] cur,
                                             input logic [63:0] d, input logic alt);
        logic [63:0] n;
        n = d & MASK;
        if (!(alt && cur[HV])) n[HV] = cur[HV];
        if (v == 0 && n[PR]) begin
            n[EE] = 1'b1; n[IR] = 1'b1; n[DR] = 1'b1;
        end
        return n;
    endfunction

    function automatic logic [10:0] ref_flags(input int v, input logic [63:0] m);
        logic [2:0] im, dm;
        logic hvf;
        if (v == 0) begin
            im = {m[HV], !m[IR], !m[PR]};
            dm = {m[HV], !m[DR], !m[PR]};
            hvf = m[HV];
        end else begin
            im = {m[GS], m[IS], !m[PR]};
            dm = {m[GS], m[DS], !m[PR]};
            hvf = 1'b1;
        end
        return {m[LE], m[FP], m[DR], m[PR], hvf, im, dm};
    endfunction

    // Advance the reference model at each edge from the stable inputs.
    always @(posedge clk) begin
        for (int v = 0; v < 2; v++) begin
            if (!rst_n) begin
                m_msr[v] = (v == 0) ? RST_S : RST_E;
                m_pre[v] = '0; m_fl[v] = 1'b0; m_sw[v] = 1'b0; m_ht[v] = 1'b0;
            end else begin
                m_fl[v] = 1'b0;
                m_sw[v] = 1'b0;
                if (wr_en) begin
                    logic [63:0] n;
                    n = ref_next(v, m_msr[v], wr_data, wr_alter_hv);
                    m_fl[v] = (n[IR] != m_msr[v][IR]) || (n[DR] != m_msr[v][DR]);
                    m_sw[v] = n[TG] != m_msr[v][TG];
                    if (n[EP] != m_msr[v][EP]) m_pre[v] = n[EP] ? 64'hFFF0_0000 : 64'h0;
                    if (n[POW] && !irq_pending && pow_permit) m_ht[v] = 1'b1;
                    m_msr[v] = n;
                end
                if (irq_pending) m_ht[v] = 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R1/R2/R3 server msr", msr_s, m_msr[0]);
            chk("R1/R2 embedded msr", msr_e, m_msr[1]);
            chk("R4 server flush", {63'b0, fl_s}, {63'b0, m_fl[0]});
            chk("R4 embedded flush", {63'b0, fl_e}, {63'b0, m_fl[1]});
            chk("R5 swap", {62'b0, sw_s, sw_e}, {62'b0, m_sw[0], m_sw[1]});
            chk("R6 server prefix", pre_s, m_pre[0]);
            chk("R6 embedded prefix", pre_e, m_pre[1]);
            chk("R7/R8 halt", {62'b0, ht_s, ht_e}, {62'b0, m_ht[0], m_ht[1]});
            chk("R9/R10 server flags", {53'b0, flg_s}, {53'b0, ref_flags(0, m_msr[0])});
            chk("R9/R11 embedded flags", {53'b0, flg_e}, {53'b0, ref_flags(1, m_msr[1])});
        end
    end

    task automatic wr(input logic [63:0] d, input logic alt);
        wr_data = d; wr_alter_hv = alt; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        // R12: reset state of both instances.
        chk("R12 reset msr", msr_s, RST_S);
        chk("R12 reset flags server", {53'b0, flg_s}, 64'h07F);
        chk("R12 reset flags embedded", {53'b0, flg_e}, 64'h049);
        chk("R12 reset outputs", {pre_s[31:0], 28'b0, fl_s, sw_s, ht_s, ht_e}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1, R2, R3: all ones without alter: bit 40 masked, HV kept.
        wr(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        chk("R1 masked bit 40", {63'b0, msr_s[40]}, 64'h0);
        chk("R2 hv kept", {63'b0, msr_s[HV]}, 64'h1);
        // R2: privileged write clears HV while it is set.
        wr(64'h0, 1'b1);
        chk("R2 hv cleared", {63'b0, msr_s[HV]}, 64'h0);
        // R2: cannot be set again once clear.
        wr(64'h1000_0000_0000_0000, 1'b1);
        chk("R2 hv blocked", {63'b0, msr_s[HV]}, 64'h0);
        // R3: problem state forces EE, IR, DR on the server instance only.
        wr(64'h0000_0000_0000_4000, 1'b0);
        chk("R3 forced bits", {61'b0, msr_s[EE], msr_s[IR], msr_s[DR]}, 64'h7);
        chk("R3 embedded not forced", {61'b0, msr_e[EE], msr_e[IR], msr_e[DR]}, 64'h0);
        // R5, R6: toggle TGPR and EP.
        wr(64'h0000_0000_0002_0040, 1'b0);
        chk("R6 prefix high", pre_s, 64'hFFF0_0000);
        wr(64'h0, 1'b0);
        chk("R6 prefix low", pre_e, 64'h0);
        // R7, R8: power save with permit, then an interrupt.
        pow_permit = 1'b1;
        wr(64'h0000_0000_0004_0000, 1'b0);
        chk("R7 halt set", {62'b0, ht_s, ht_e}, 64'h3);
        irq_pending = 1'b1;
        @(negedge clk);
        chk("R8 halt cleared", {62'b0, ht_s, ht_e}, 64'h0);
        irq_pending = 1'b0;
        // R11: guest state and address-space bits on the embedded instance.
        wr(64'h0000_0000_1000_0030, 1'b0);
        chk("R11 embedded idx", {58'b0, flg_e[5:0]}, 64'h3F);
        // Random phase with one mid-run reset.
        for (int i = 0; i < 3000; i++) begin
            wr_en       = ($urandom_range(1) == 1);
            wr_data     = {$urandom, $urandom} & (($urandom_range(3) == 0) ? 64'hFFFF_FFFF_FFFF_FFFF
                                                                        : 64'h1000_0000_1006_4071);
            wr_alter_hv = ($urandom_range(1) == 1);
            irq_pending = ($urandom_range(4) == 0);
            pow_permit  = ($urandom_range(2) != 0);
            rst_n       = !(i == 1500 || i == 1501);
            @(negedge clk);
        end
        wr_en = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule